// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, cycle by cycle, whether one floating-point operation may be issued to a unit that has two execution paths. The first is a pipelined path for add, multiply and multiply-add. The second is a separate iterative path for divide and square root, which does not pipeline. The block does no arithmetic. It models occupancy and timing only. For each request it checks three things: that the path the operation needs can take it, that both source registers and the destination register hold settled values, and that the operation code is legal.

Once it accepts an operation, the block clears the ready bit of the destination register. When the latency for that operation and precision has elapsed, it raises a write-back strobe carrying the destination index, and the ready bit sets again one cycle later. Double precision costs one extra cycle of occupancy and one extra cycle of latency on multiply and multiply-add. The long operations occupy the iterative path for a count of cycles that depends on the operation and the precision.

The block has a single write-back port. The pipelined path always has priority on it, so a divide or square-root result that comes due in the same cycle retires one cycle later.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: A synchronous active-low reset sets every register ready and empties both paths. After reset no write-back occurs, and a divide is accepted in the first cycle after reset is released.
- R2: Add (op code 0) is accepted every cycle. Its write-back comes 4 cycles after the accept cycle in single precision (`iss_dbl`=0) and in double precision (`iss_dbl`=1).
- R3: Single-precision multiply (op 1) and multiply-add (op 2) have a latency of 4 cycles. They can be accepted on consecutive cycles, and their write-backs then appear on consecutive cycles in issue order.
- R4: Double-precision multiply and multiply-add have a latency of 5 cycles. No pipelined operation is accepted in the cycle directly after one; a pipelined operation is accepted in the cycle after that.
- R5: Divide (op 3) has a latency of 21 cycles in single precision and 36 in double. Square root (op 4) has a latency of 38 in single and 68 in double.
- R6: After a divide or square root is accepted, the next divide or square root is refused until the issue interval has passed: 19 and 34 cycles for divide (single, double), 36 and 66 for square root. Pipelined operations are still accepted during that time.
- R7: The destination's bit in `reg_ready` is low from the cycle after the accept through the write-back cycle, and high again in the cycle after the write-back.
- R8: A request is refused while either source register or the destination register is not ready.
- R9: When a pipelined result and an iterative result come due in the same cycle, the pipelined result is written back in that cycle and the iterative result in the next cycle.
- R10: Op codes 5, 6 and 7 are never accepted. They produce no write-back and leave the destination ready.
- R11: `iss_ack` is low whenever `iss_req` is low, and such a cycle changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_req | input | 1 | Issue request for the operation on the other issue inputs |
| iss_op | input | 3 | Operation: 0 add, 1 multiply, 2 multiply-add, 3 divide, 4 square root |
| iss_dbl | input | 1 | 1 = double precision, 0 = single precision |
| iss_dst | input | 5 | Destination register index |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_ack | output | 1 | The request is accepted in this cycle |
| reg_ready | output | 32 | One ready bit per register |
| wb_vld | output | 1 | Write-back strobe |
| wb_reg | output | 5 | Register written back while wb_vld is high |

## Verification
Cycles are counted from the cycle in which a request is accepted. The write-back strobe is due exactly as many cycles later as the latency listed under R2 to R5, the ready bit rises one cycle after that, and the next long operation is accepted exactly one issue interval later. The bench drives inputs on the falling edge and samples outputs shortly after it. It counts falling edges from the accepting cycle until the strobe appears and compares that count with the latency computed from the requirement. Refusal windows and priority collisions are checked one cycle before and at the cycle where the outcome is due to change, so that an error of one cycle in either direction shows up.

// File: rtl/fpsb_pkg.sv
// Package: shared constants and types for the floating-point issue scoreboard.
// Holds the timing of each operation class and the decoded-timing record.
// Assumes the opcode encoding listed in the brief.
package fpsb_pkg;

    localparam int LAT_LONGEST = 68;
    localparam int CNT_W       = $clog2(LAT_LONGEST + 1);
    localparam int PIPE_DEPTH  = 5;   // longest pipelined latency

    localparam logic [2:0] OPC_ADD  = 3'd0;
    localparam logic [2:0] OPC_MUL  = 3'd1;
    localparam logic [2:0] OPC_MADD = 3'd2;
    localparam logic [2:0] OPC_DIV  = 3'd3;
    localparam logic [2:0] OPC_SQRT = 3'd4;

    // issue interval / latency pairs
    localparam int ADD_II = 1,    ADD_LAT = 4;
    localparam int MULS_II = 1,   MULS_LAT = 4;
    localparam int MULD_II = 2,   MULD_LAT = 5;
    localparam int DIVS_II = 19,  DIVS_LAT = 21;
    localparam int DIVD_II = 34,  DIVD_LAT = 36;
    localparam int SQRS_II = 36,  SQRS_LAT = 38;
    localparam int SQRD_II = 66,  SQRD_LAT = 68;

    typedef struct packed {
        logic             legal;
        logic             iter;   // goes to the divide/square-root path
        logic [CNT_W-1:0] ii;
        logic [CNT_W-1:0] lat;
    } op_timing_t;

endpackage

// File: rtl/fpsb_decode.sv
// Module: fpsb_decode
// Maps an opcode and a precision bit to a path selection, an issue
// interval and a latency. Purely combinational. Codes above 4 are illegal.
module fpsb_decode
    import fpsb_pkg::*;
(
    input  logic [2:0]  op,
    input  logic        dbl,
    output op_timing_t  tim
);

    // Timing lookup per operation class.
    always_comb begin
        tim = '0;
        case (op)
            OPC_ADD: begin
                tim.legal = 1'b1;
                tim.ii    = CNT_W'(ADD_II);
                tim.lat   = CNT_W'(ADD_LAT);
            end
            OPC_MUL, OPC_MADD: begin
                tim.legal = 1'b1;
                tim.ii    = dbl ? CNT_W'(MULD_II)  : CNT_W'(MULS_II);
                tim.lat   = dbl ? CNT_W'(MULD_LAT) : CNT_W'(MULS_LAT);
            end
            OPC_DIV: begin
                tim.legal = 1'b1;
                tim.iter  = 1'b1;
                tim.ii    = dbl ? CNT_W'(DIVD_II)  : CNT_W'(DIVS_II);
                tim.lat   = dbl ? CNT_W'(DIVD_LAT) : CNT_W'(DIVS_LAT);
            end
            OPC_SQRT: begin
                tim.legal = 1'b1;
                tim.iter  = 1'b1;
                tim.ii    = dbl ? CNT_W'(SQRD_II)  : CNT_W'(SQRS_II);
                tim.lat   = dbl ? CNT_W'(SQRD_LAT) : CNT_W'(SQRS_LAT);
            end
            default: tim = '0;
        endcase
    end

endmodule

// File: rtl/fpsb_pipe_track.sv
// Module: fpsb_pipe_track
// Tracks results in flight on the pipelined path with a shift line of
// slots. Slot i holds the result that retires i cycles from now. An accept
// with latency L loads slot L-1. A gap counter blocks new accepts while a
// double-precision multiply still occupies the path.
// Assumes acc is raised only while busy is low and that lat <= DEPTH.
module fpsb_pipe_track
    import fpsb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [CNT_W-1:0] acc_ii,
    input  logic [CNT_W-1:0] acc_lat,
    input  logic [REG_W-1:0] acc_reg,
    output logic             busy,
    output logic             ret_vld,
    output logic [REG_W-1:0] ret_reg
);

    logic             vld_q [DEPTH];
    logic             vld_d [DEPTH];
    logic [REG_W-1:0] reg_q [DEPTH];
    logic [REG_W-1:0] reg_d [DEPTH];
    logic [CNT_W-1:0] gap_q;

    // Next state of each slot: load on accept, otherwise shift down.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic load;
        assign load = acc && (acc_lat == CNT_W'(i + 1));
        if (i == DEPTH - 1) begin : g_last
            assign vld_d[i] = load;
            assign reg_d[i] = load ? acc_reg : '0;
        end else begin : g_mid
            assign vld_d[i] = load | vld_q[i+1];
            assign reg_d[i] = load ? acc_reg : reg_q[i+1];
            // R3/R4: a new result never lands on a slot already in use
            a_r4_no_slot_clash: assert property (@(posedge clk) disable iff (!rst_n)
                !(load && vld_q[i+1]));
        end
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                reg_q[i] <= '0;
            end else begin
                vld_q[i] <= vld_d[i];
                reg_q[i] <= reg_d[i];
            end
        end
    end

    // Occupancy gap counter for issue intervals above one.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_q <= '0;
        else if (acc)            gap_q <= acc_ii - CNT_W'(1);
        else if (gap_q != '0)    gap_q <= gap_q - CNT_W'(1);
    end

    assign busy    = (gap_q != '0);
    assign ret_vld = vld_q[0];
    assign ret_reg = reg_q[0];

    // R4: a double-precision multiply blocks the following cycle
    a_r4_pipe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_ii == CNT_W'(2)) |=> !acc);

endmodule

// File: rtl/fpsb_div_track.sv
// Module: fpsb_div_track
// Occupancy and result tracking for the non-pipelined divide/square-root
// path. A busy counter enforces the issue interval. Because the latency
// exceeds the interval, a small set of result slots each count down one
// outstanding latency. A slot whose count has reached zero retires when
// the write-back port is not taken by the pipelined path (blocked).
// Assumes acc is raised only while busy is low.
module fpsb_div_track
    import fpsb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [CNT_W-1:0] acc_ii,
    input  logic [CNT_W-1:0] acc_lat,
    input  logic [REG_W-1:0] acc_reg,
    input  logic             blocked,
    output logic             busy,
    output logic             ret_vld,
    output logic [REG_W-1:0] ret_reg
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic             vld_q [SLOTS];
    logic             vld_d [SLOTS];
    logic [CNT_W-1:0] cnt_q [SLOTS];
    logic [CNT_W-1:0] cnt_d [SLOTS];
    logic [REG_W-1:0] reg_q [SLOTS];
    logic [REG_W-1:0] reg_d [SLOTS];
    logic [CNT_W-1:0] busy_q;
    logic [SLOT_W-1:0] alloc_idx, ret_idx;
    logic             alloc_ok, due_found;

    // Pick the lowest free slot and the lowest slot whose result is due.
    always_comb begin
        alloc_idx = '0;
        alloc_ok  = 1'b0;
        ret_idx   = '0;
        due_found = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                alloc_idx = SLOT_W'(i);
                alloc_ok  = 1'b1;
            end
            if (vld_q[i] && cnt_q[i] == '0) begin
                ret_idx   = SLOT_W'(i);
                due_found = 1'b1;
            end
        end
    end

    assign ret_vld = due_found && !blocked;
    assign ret_reg = reg_q[ret_idx];

    // Next state per result slot.
    for (genvar i = 0; i < SLOTS; i++) begin : g_res
        logic take, drop;
        assign take     = acc && (alloc_idx == SLOT_W'(i));
        assign drop     = ret_vld && (ret_idx == SLOT_W'(i));
        assign vld_d[i] = take | (vld_q[i] & ~drop);
        assign cnt_d[i] = take ? (acc_lat - CNT_W'(1))
                        : (vld_q[i] && cnt_q[i] != '0) ? (cnt_q[i] - CNT_W'(1))
                        : cnt_q[i];
        assign reg_d[i] = take ? acc_reg : reg_q[i];
    end

    // Result slot registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                cnt_q[i] <= '0;
                reg_q[i] <= '0;
            end else begin
                vld_q[i] <= vld_d[i];
                cnt_q[i] <= cnt_d[i];
                reg_q[i] <= reg_d[i];
            end
        end
    end

    // Issue-interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            busy_q <= '0;
        else if (acc)          busy_q <= acc_ii - CNT_W'(1);
        else if (busy_q != '0) busy_q <= busy_q - CNT_W'(1);
    end

    assign busy = (busy_q != '0) || !alloc_ok;

    // R6: nothing is accepted while the interval counter runs
    a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0) |-> !acc);
    // R6: the interval counter steps down by one each idle cycle
    a_r6_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0) |=> (busy_q == CNT_W'($past(busy_q) - CNT_W'(1))));
    // R9: a due result that is held back stays due in the next cycle
    a_r9_defer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (due_found && blocked) |=> due_found);

endmodule

// File: rtl/fpsb_ready_bits.sv
// Module: fpsb_ready_bits
// One ready flag per register. The flag is cleared when an operation
// writing that register is accepted and set when its write-back occurs.
// Assumes the clear and set targets never coincide.
module fpsb_ready_bits #(
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    output logic [NREG-1:0]  ready
);

    logic [NREG-1:0] rdy_q, rdy_d;

    // Apply write-back set and issue clear.
    always_comb begin
        rdy_d = rdy_q;
        if (set_en) rdy_d[set_idx] = 1'b1;
        if (clr_en) rdy_d[clr_idx] = 1'b0;
    end

    // Flag register; reset marks every register ready.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '1;
        else        rdy_q <= rdy_d;
    end

    assign ready = rdy_q;

    // R7: a write-back only targets a register that is pending
    a_r7_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !rdy_q[set_idx]);
    // R8: an accepted destination was ready
    a_r8_clr_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> rdy_q[clr_idx]);

endmodule

// File: rtl/fp_issue_scoreboard.sv
// Module: fp_issue_scoreboard (top)
// Issue control for a floating-point unit with a pipelined path and an
// iterative divide/square-root path. Accepts a request when the opcode is
// legal, all named registers are ready and the selected path is free.
// Merges both result streams onto one write-back port, with the pipelined
// path taking priority. Models timing only, not arithmetic.
module fp_issue_scoreboard
    import fpsb_pkg::*;
#(
    parameter int NREG      = 32,
    parameter int DIV_SLOTS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_req,
    input  logic [2:0]              iss_op,
    input  logic                    iss_dbl,
    input  logic [$clog2(NREG)-1:0] iss_dst,
    input  logic [$clog2(NREG)-1:0] iss_src_a,
    input  logic [$clog2(NREG)-1:0] iss_src_b,
    output logic                    iss_ack,
    output logic [NREG-1:0]         reg_ready,
    output logic                    wb_vld,
    output logic [$clog2(NREG)-1:0] wb_reg
);

    localparam int REG_W = $clog2(NREG);

    op_timing_t       tim;
    logic             pipe_busy, div_busy;
    logic             pipe_ret, div_ret;
    logic [REG_W-1:0] pipe_ret_reg, div_ret_reg;
    logic             regs_ok, path_ok, pipe_acc, div_acc;

    fpsb_decode u_decode (
        .op  (iss_op),
        .dbl (iss_dbl),
        .tim (tim)
    );

    // Accept decision: legal code, settled operands, free path.
    always_comb begin
        regs_ok = reg_ready[iss_src_a] && reg_ready[iss_src_b] && reg_ready[iss_dst];
        path_ok = tim.iter ? !div_busy : !pipe_busy;
        iss_ack = iss_req && tim.legal && regs_ok && path_ok;
    end

    assign pipe_acc = iss_ack && !tim.iter;
    assign div_acc  = iss_ack &&  tim.iter;

    fpsb_pipe_track #(
        .REG_W (REG_W),
        .DEPTH (PIPE_DEPTH)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (pipe_acc),
        .acc_ii  (tim.ii),
        .acc_lat (tim.lat),
        .acc_reg (iss_dst),
        .busy    (pipe_busy),
        .ret_vld (pipe_ret),
        .ret_reg (pipe_ret_reg)
    );

    fpsb_div_track #(
        .REG_W (REG_W),
        .SLOTS (DIV_SLOTS)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (div_acc),
        .acc_ii  (tim.ii),
        .acc_lat (tim.lat),
        .acc_reg (iss_dst),
        .blocked (pipe_ret),
        .busy    (div_busy),
        .ret_vld (div_ret),
        .ret_reg (div_ret_reg)
    );

    // Write-back merge with the pipelined path first.
    assign wb_vld = pipe_ret | div_ret;
    assign wb_reg = pipe_ret ? pipe_ret_reg : div_ret_reg;

    fpsb_ready_bits #(
        .NREG  (NREG),
        .REG_W (REG_W)
    ) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (iss_ack),
        .clr_idx (iss_dst),
        .set_en  (wb_vld),
        .set_idx (wb_reg),
        .ready   (reg_ready)
    );

    // R9: the two paths never retire in the same cycle
    a_r9_wb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pipe_ret, div_ret}));
    // R7: the destination shows not ready in the cycle after accept
    a_r7_dst_pending: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ack |=> !reg_ready[$past(iss_dst)]);
    // R10: codes above 4 are refused
    a_r10_illegal_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_op > 3'd4) |-> !iss_ack);
    // R11: no accept without a request
    a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_req |-> !iss_ack);

endmodule

// File: tb/fp_issue_scoreboard_tb.sv
// Bench for fp_issue_scoreboard: a table of operations with expected
// latencies, then directed cases for reset, intervals, stalls and priority.
// Inputs change on the falling edge; outputs are sampled 1 ns after it.
module fp_issue_scoreboard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_req = 1'b0;
    logic [2:0]  iss_op = 3'd0;
    logic        iss_dbl = 1'b0;
    logic [4:0]  iss_dst = 5'd0;
    logic [4:0]  iss_src_a = 5'd0;
    logic [4:0]  iss_src_b = 5'd0;
    logic        iss_ack;
    logic [31:0] reg_ready;
    logic        wb_vld;
    logic [4:0]  wb_reg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fp_issue_scoreboard dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_req   (iss_req),
        .iss_op    (iss_op),
        .iss_dbl   (iss_dbl),
        .iss_dst   (iss_dst),
        .iss_src_a (iss_src_a),
        .iss_src_b (iss_src_b),
        .iss_ack   (iss_ack),
        .reg_ready (reg_ready),
        .wb_vld    (wb_vld),
        .wb_reg    (wb_reg)
    );

    // op[11:9], dbl[8], expected latency[7:0]
    localparam logic [11:0] VECS [10] = '{
        {3'd0, 1'b0, 8'd4},  {3'd0, 1'b1, 8'd4},
        {3'd1, 1'b0, 8'd4},  {3'd1, 1'b1, 8'd5},
        {3'd2, 1'b0, 8'd4},  {3'd2, 1'b1, 8'd5},
        {3'd3, 1'b0, 8'd21}, {3'd3, 1'b1, 8'd36},
        {3'd4, 1'b0, 8'd38}, {3'd4, 1'b1, 8'd68}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic dbl, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b, output logic ack);
        @(negedge clk);
        iss_req = 1'b1; iss_op = op; iss_dbl = dbl;
        iss_dst = d; iss_src_a = a; iss_src_b = b;
        #1 ack = iss_ack;
    endtask

    task automatic step();
        @(negedge clk);
        iss_req = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic dbl);
        if (op == 3'd0) return "R2";
        if (op == 3'd1 || op == 3'd2) return dbl ? "R4" : "R3";
        return "R5";
    endfunction

    // R6: refusal one cycle before the interval ends, accept at its end
    task automatic tput_case(input logic [2:0] op, input logic dbl, input int ii,
                             input logic [4:0] d1, input logic [4:0] d2);
        logic ack;
        issue(op, dbl, d1, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R6", int'(ack), 1);
        idle(ii - 2);
        issue(op, dbl, d2, 5'd0, 5'd0, ack);
        chk(ack == 1'b0, "R6", int'(ack), 0);
        issue(op, dbl, d2, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R6", int'(ack), 1);
        idle(150);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        idle(3);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1: reset state
        chk(reg_ready == 32'hFFFF_FFFF, "R1", int'(reg_ready[15:0]), 16'hFFFF);
        chk(wb_vld == 1'b0, "R1", int'(wb_vld), 0);

        // Table walk: latency and ready-bit timing per operation class
        for (int v = 0; v < 10; v++) begin
            logic [2:0] op;
            logic       dbl;
            int         lat_exp;
            int         got;
            logic [4:0] d;
            op = VECS[v][11:9];
            dbl = VECS[v][8];
            lat_exp = int'(VECS[v][7:0]);
            d = 5'(v + 1);
            got = 0;
            issue(op, dbl, d, 5'd0, 5'd0, ack);
            chk(ack == 1'b1, tag_of(op, dbl), int'(ack), 1);
            for (int k = 1; k <= 100; k++) begin
                step();
                if (k == 1) chk(reg_ready[d] == 1'b0, "R7", int'(reg_ready[d]), 0);
                if (wb_vld) begin
                    got = k;
                    break;
                end
            end
            chk(got == lat_exp, tag_of(op, dbl), got, lat_exp);
            chk(wb_reg == d, tag_of(op, dbl), int'(wb_reg), int'(d));
            chk(reg_ready[d] == 1'b0, "R7", int'(reg_ready[d]), 0);
            step();
            chk(reg_ready[d] == 1'b1, "R7", int'(reg_ready[d]), 1);
            idle(3);
        end

        // R3: single multiply-add every cycle, write-backs in order
        for (int i = 0; i < 4; i++) begin
            issue(3'd2, 1'b0, 5'(10 + i), 5'd0, 5'd0, ack);
            chk(ack == 1'b1, "R3", int'(ack), 1);
        end
        for (int i = 0; i < 4; i++) begin
            step();
            chk(wb_vld && wb_reg == 5'(10 + i), "R3", int'(wb_reg), 10 + i);
        end
        idle(3);

        // R4: double multiply blocks one cycle, latency order kept
        issue(3'd1, 1'b1, 5'd14, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R4", int'(ack), 1);
        issue(3'd0, 1'b0, 5'd15, 5'd0, 5'd0, ack);
        chk(ack == 1'b0, "R4", int'(ack), 0);
        issue(3'd0, 1'b0, 5'd15, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R4", int'(ack), 1);
        idle(3);
        chk(wb_vld && wb_reg == 5'd14, "R4", int'(wb_reg), 14);
        step();
        chk(wb_vld && wb_reg == 5'd15, "R4", int'(wb_reg), 15);
        idle(3);

        // R6: issue intervals of the iterative path
        tput_case(3'd3, 1'b0, 19, 5'd16, 5'd17);
        tput_case(3'd3, 1'b1, 34, 5'd16, 5'd17);
        tput_case(3'd4, 1'b0, 36, 5'd16, 5'd17);
        tput_case(3'd4, 1'b1, 66, 5'd16, 5'd17);

        // R6: pipelined path stays open while divide is busy
        issue(3'd3, 1'b0, 5'd26, 5'd0, 5'd0, ack);
        issue(3'd1, 1'b0, 5'd27, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R6", int'(ack), 1);
        idle(30);

        // R8: stalls on unready source or destination
        issue(3'd3, 1'b0, 5'd20, 5'd0, 5'd0, ack);
        issue(3'd0, 1'b0, 5'd21, 5'd20, 5'd0, ack);
        chk(ack == 1'b0, "R8", int'(ack), 0);
        issue(3'd0, 1'b0, 5'd21, 5'd0, 5'd20, ack);
        chk(ack == 1'b0, "R8", int'(ack), 0);
        issue(3'd0, 1'b0, 5'd20, 5'd0, 5'd0, ack);
        chk(ack == 1'b0, "R8", int'(ack), 0);
        issue(3'd0, 1'b0, 5'd21, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R8", int'(ack), 1);
        idle(30);

        // R9: same-cycle retirement, pipelined result first
        issue(3'd3, 1'b0, 5'd22, 5'd0, 5'd0, ack);
        idle(16);
        issue(3'd0, 1'b0, 5'd23, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R9", int'(ack), 1);
        idle(3);
        chk(wb_vld == 1'b0, "R9", int'(wb_vld), 0);
        step();
        chk(wb_vld && wb_reg == 5'd23, "R9", int'(wb_reg), 23);
        step();
        chk(wb_vld && wb_reg == 5'd22, "R9", int'(wb_reg), 22);
        idle(3);

        // R10: illegal codes refused with no effect
        for (int c = 5; c < 8; c++) begin
            issue(3'(c), 1'b0, 5'd28, 5'd0, 5'd0, ack);
            chk(ack == 1'b0, "R10", int'(ack), 0);
        end
        for (int i = 0; i < 8; i++) begin
            step();
            chk(wb_vld == 1'b0, "R10", int'(wb_vld), 0);
        end
        chk(reg_ready[28] == 1'b1, "R10", int'(reg_ready[28]), 1);

        // R11: no request, no accept, no state change
        @(negedge clk);
        iss_req = 1'b0; iss_op = 3'd0; iss_dst = 5'd29; iss_src_a = 5'd0; iss_src_b = 5'd0;
        #1 chk(iss_ack == 1'b0, "R11", int'(iss_ack), 0);
        step();
        chk(reg_ready[29] == 1'b1, "R11", int'(reg_ready[29]), 1);

        // R1: reset mid-operation clears busy state and ready bits
        issue(3'd4, 1'b1, 5'd24, 5'd0, 5'd0, ack);
        @(negedge clk); iss_req = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(reg_ready == 32'hFFFF_FFFF, "R1", int'(reg_ready[24]), 1);
        issue(3'd3, 1'b0, 5'd25, 5'd0, 5'd0, ack);
        chk(ack == 1'b1, "R1", int'(ack), 1);
        idle(80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule